// File: doc/BRIEF.md
# Keyboard and Mouse Byte Source

This block turns emulated input-device activity into the byte stream that a serial receive channel would deliver to software. Key events (an already-translated keycode plus a press or release flag), mouse events (signed horizontal and vertical motion plus three buttons) and command bytes that the host writes toward the device are each converted into zero or more bytes. The bytes are placed in a small circular queue, and the receive side takes them one at a time with a pop strobe while a byte-available flag is high.

A single sequencer state machine accepts one event at a time through a ready/valid handshake and writes the resulting bytes into the queue, one per clock. The states are IDLE (accepts events, filters lock keys, decodes host commands, issues queue flushes), KEY (pushes one key byte), M_HDR, M_DX, M_DY, M_PAD0, M_PAD1 (push the five bytes of a mouse packet in order), RST_ID0, RST_ID1, RST_ID2 (push the three-byte reply to an identify command) and LAY_ID0, LAY_ID1 (push the two-byte reply to a layout query). Transitions: IDLE goes to KEY on an accepted, unfiltered key; to M_HDR on an accepted mouse event; to RST_ID0 on a live identify command; to LAY_ID0 on a live layout query; and stays in IDLE for filtered keys, ignored host bytes and the LED-arm command. Every push state advances to the next push state of its sequence, and the last one of each sequence returns to IDLE.

Lock keys (caps and num) are filtered with a two-bit toggle state each, so that one physical press-release pair of a latching key is reported as a single press and the next pair as a single release.

Top module: `kbd_mouse_src`

## Requirements
- R1: After reset out_avail is 0, out_byte is 0x00 and ev_ready is 1.
- R2: The queue returns bytes in the order they were pushed and holds at most DEPTH bytes; a push while DEPTH bytes are held is discarded and the first DEPTH bytes are kept.
- R3: While the queue is empty out_byte reads 0x00, and a pop while empty changes nothing.
- R4: After a pop, out_avail stays 1 as long as at least one byte remains.
- R5: A key press pushes key_code unchanged; a key release (key_up=1) pushes key_code with bit 7 set.
- R6: key_lock selects 0 none, 1 caps, 2 num (3 behaves as none). Each lock key has its own 2-bit state starting at 0 that is XORed with 1 on press and with 2 on release; a press is dropped when the new state is 2, a release is dropped when the new state is 3.
- R7: A mouse event pushes first a header byte 0x87 with bit 2 cleared when mouse_btn[2] (left) is 1, bit 1 cleared when mouse_btn[1] (middle) is 1, bit 0 cleared when mouse_btn[0] (right) is 1.
- R8: The header is followed by mouse_dx, then the negation of mouse_dy, each taken as signed, limited to -127..+127 and sent as an 8-bit two's complement value, then two 0x00 bytes.
- R9: Host byte 0x01 empties the queue and then pushes 0xFF, 0x04, 0x7F.
- R10: Host byte 0x0E causes the next live host byte to be ignored.
- R11: Host bytes 0x07 and 0x0F empty the queue and then push 0xFE, 0x21.
- R12: Host bytes are acted on only when tx_enable is 1 and chan_disable is 0; otherwise, and for any other byte value, the queue and the LED-arm flag are unchanged.
- R13: An event is taken in a cycle where its valid and ev_ready are both 1; when several are valid, the key is taken first, then the mouse, then the host byte; ev_ready is 0 while a sequence is being pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key event offered |
| key_code | input | 8 | Translated keycode |
| key_up | input | 1 | 1 = release, 0 = press |
| key_lock | input | 2 | Lock key select: 0 none, 1 caps, 2 num |
| mouse_valid | input | 1 | Mouse event offered |
| mouse_dx | input | MW | Signed horizontal motion |
| mouse_dy | input | MW | Signed vertical motion |
| mouse_btn | input | 3 | Buttons: bit2 left, bit1 middle, bit0 right |
| host_valid | input | 1 | Host command byte offered |
| host_byte | input | 8 | Host command byte |
| tx_enable | input | 1 | Transmit side enabled |
| chan_disable | input | 1 | Channel disabled |
| ev_ready | output | 1 | Sequencer can take an event |
| out_avail | output | 1 | Queue holds at least one byte |
| out_byte | output | 8 | Byte at the queue head, 0 when empty |
| out_pop | input | 1 | Remove the head byte |

## Verification
The bench sweeps mouse motion across the saturation edges (-512, -128, -127, 127, 128, 511) for every button combination, where a design that clipped at 128 or forgot to negate the vertical axis would emit wrong motion bytes. It fills the queue past its depth and then pops it empty, catching a queue that overwrote old bytes or returned stale data on an empty pop. Host command handling is probed with transmit disabled, the channel disabled, the LED-arm swallow, and unknown bytes, where a wrong design would flush or answer when it must not. Lock-key sequences and simultaneous key/mouse/host events expose a wrong drop rule or a wrong acceptance order.

// File: rtl/kms_pkg.sv
package kms_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_KEY,
        ST_M_HDR,
        ST_M_DX,
        ST_M_DY,
        ST_M_PAD0,
        ST_M_PAD1,
        ST_RST_ID0,
        ST_RST_ID1,
        ST_RST_ID2,
        ST_LAY_ID0,
        ST_LAY_ID1
    } seq_state_e;

    localparam logic [1:0] LOCK_NONE = 2'd0;
    localparam logic [1:0] LOCK_CAPS = 2'd1;
    localparam logic [1:0] LOCK_NUM  = 2'd2;

    localparam logic [7:0] CMD_IDENT  = 8'h01;
    localparam logic [7:0] CMD_LEDARM = 8'h0E;
    localparam logic [7:0] CMD_LAY_A  = 8'h07;
    localparam logic [7:0] CMD_LAY_B  = 8'h0F;

    localparam logic [7:0] RPL_ID0  = 8'hFF;
    localparam logic [7:0] RPL_ID1  = 8'h04;
    localparam logic [7:0] RPL_ID2  = 8'h7F;
    localparam logic [7:0] RPL_LAY0 = 8'hFE;
    localparam logic [7:0] RPL_LAY1 = 8'h21;

    localparam logic [7:0] MOUSE_HDR_BASE = 8'h87;

endpackage

// File: rtl/kms_fifo.sv
module kms_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [7:0]    head,
    output logic          not_empty,
    output logic [CW-1:0] count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign push_ok   = push && (count != CW'(DEPTH));
    assign pop_ok    = pop && (count != '0);
    assign not_empty = (count != '0);
    assign head      = not_empty ? mem[rptr] : 8'h00;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= step(wptr);
            if (pop_ok)  rptr <= step(rptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wptr] <= push_data;
    end
endmodule

// File: rtl/kms_lock_filter.sv
module kms_lock_filter
    import kms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic [1:0] sel,
    input  logic       key_up,
    output logic       pass
);
    logic [1:0] lk_st [2];
    logic [1:0] flip;

    assign flip = key_up ? 2'b10 : 2'b01;

    for (genvar g = 0; g < 2; g++) begin : g_lock
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lk_st[g] <= 2'b00;
            end else if (take && (sel == 2'(g + 1))) begin
                lk_st[g] <= lk_st[g] ^ flip;
            end
        end
    end

    always_comb begin
        logic [1:0] nxt;
        nxt  = 2'b00;
        pass = 1'b1;
        if (sel == LOCK_CAPS || sel == LOCK_NUM) begin
            nxt  = lk_st[(sel == LOCK_CAPS) ? 0 : 1] ^ flip;
            pass = key_up ? (nxt != 2'b11) : (nxt != 2'b10);
        end
    end
endmodule

// File: rtl/kms_mouse_enc.sv
module kms_mouse_enc
    import kms_pkg::*;
#(
    parameter int MW = 10
) (
    input  logic [MW-1:0] dx,
    input  logic [MW-1:0] dy,
    input  logic [2:0]    btn,
    output logic [7:0]    hdr,
    output logic [7:0]    mx,
    output logic [7:0]    my
);
    localparam int EW = MW + 1;
    localparam logic signed [EW-1:0] POS_LIM = EW'(127);
    localparam logic signed [EW-1:0] NEG_LIM = -EW'(127);

    logic signed [EW-1:0] dx_e, dy_e, dy_n;

    function automatic logic [7:0] clamp(input logic signed [EW-1:0] v);
        if (v > POS_LIM)      return 8'h7F;
        else if (v < NEG_LIM) return 8'h81;
        else                  return v[7:0];
    endfunction

    always_comb begin
        dx_e = EW'($signed(dx));
        dy_e = EW'($signed(dy));
        dy_n = -dy_e;
        hdr  = MOUSE_HDR_BASE ^ {5'b0, btn};
        mx   = clamp(dx_e);
        my   = clamp(dy_n);
    end
endmodule

// File: rtl/kms_seq.sv
module kms_seq
    import kms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_valid,
    input  logic [7:0] key_code,
    input  logic       key_up,
    input  logic       lock_pass,
    input  logic       mouse_valid,
    input  logic [7:0] m_hdr,
    input  logic [7:0] m_dx,
    input  logic [7:0] m_dy,
    input  logic       host_valid,
    input  logic [7:0] host_byte,
    input  logic       tx_enable,
    input  logic       chan_disable,
    output logic       ev_ready,
    output logic       lock_take,
    output logic       push,
    output logic [7:0] push_data,
    output logic       flush
);
    seq_state_e state, state_nx;
    logic [7:0] b0, b1, b2;
    logic       led_arm, led_arm_nx;
    logic       host_live;

    assign host_live = host_valid && tx_enable && !chan_disable;

    // state register and captured bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            led_arm <= 1'b0;
            b0      <= 8'h00;
            b1      <= 8'h00;
            b2      <= 8'h00;
        end else begin
            state   <= state_nx;
            led_arm <= led_arm_nx;
            if (state == ST_IDLE) begin
                if (key_valid) begin
                    b0 <= {key_up | key_code[7], key_code[6:0]};
                end else if (mouse_valid) begin
                    b0 <= m_hdr;
                    b1 <= m_dx;
                    b2 <= m_dy;
                end
            end
        end
    end

    // next state
    always_comb begin
        state_nx   = state;
        led_arm_nx = led_arm;
        unique case (state)
            ST_IDLE: begin
                if (key_valid) begin
                    state_nx = lock_pass ? ST_KEY : ST_IDLE;
                end else if (mouse_valid) begin
                    state_nx = ST_M_HDR;
                end else if (host_live) begin
                    if (led_arm) begin
                        led_arm_nx = 1'b0;
                    end else if (host_byte == CMD_IDENT) begin
                        state_nx = ST_RST_ID0;
                    end else if (host_byte == CMD_LEDARM) begin
                        led_arm_nx = 1'b1;
                    end else if (host_byte == CMD_LAY_A || host_byte == CMD_LAY_B) begin
                        state_nx = ST_LAY_ID0;
                    end
                end
            end
            ST_KEY:     state_nx = ST_IDLE;
            ST_M_HDR:   state_nx = ST_M_DX;
            ST_M_DX:    state_nx = ST_M_DY;
            ST_M_DY:    state_nx = ST_M_PAD0;
            ST_M_PAD0:  state_nx = ST_M_PAD1;
            ST_M_PAD1:  state_nx = ST_IDLE;
            ST_RST_ID0: state_nx = ST_RST_ID1;
            ST_RST_ID1: state_nx = ST_RST_ID2;
            ST_RST_ID2: state_nx = ST_IDLE;
            ST_LAY_ID0: state_nx = ST_LAY_ID1;
            ST_LAY_ID1: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ev_ready  = 1'b0;
        lock_take = 1'b0;
        push      = 1'b1;
        push_data = 8'h00;
        flush     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                push      = 1'b0;
                ev_ready  = 1'b1;
                lock_take = key_valid;
                flush     = !key_valid && !mouse_valid && host_live && !led_arm &&
                            (host_byte == CMD_IDENT || host_byte == CMD_LAY_A ||
                             host_byte == CMD_LAY_B);
            end
            ST_KEY:     push_data = b0;
            ST_M_HDR:   push_data = b0;
            ST_M_DX:    push_data = b1;
            ST_M_DY:    push_data = b2;
            ST_M_PAD0:  push_data = 8'h00;
            ST_M_PAD1:  push_data = 8'h00;
            ST_RST_ID0: push_data = RPL_ID0;
            ST_RST_ID1: push_data = RPL_ID1;
            ST_RST_ID2: push_data = RPL_ID2;
            ST_LAY_ID0: push_data = RPL_LAY0;
            ST_LAY_ID1: push_data = RPL_LAY1;
            default:    push = 1'b0;
        endcase
    end
endmodule

// File: rtl/kbd_mouse_src.sv
module kbd_mouse_src
    import kms_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int MW    = 10,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_valid,
    input  logic [7:0]    key_code,
    input  logic          key_up,
    input  logic [1:0]    key_lock,
    input  logic          mouse_valid,
    input  logic [MW-1:0] mouse_dx,
    input  logic [MW-1:0] mouse_dy,
    input  logic [2:0]    mouse_btn,
    input  logic          host_valid,
    input  logic [7:0]    host_byte,
    input  logic          tx_enable,
    input  logic          chan_disable,
    output logic          ev_ready,
    output logic          out_avail,
    output logic [7:0]    out_byte,
    input  logic          out_pop
);
    logic          lock_pass, lock_take;
    logic [7:0]    m_hdr, m_dx, m_dy;
    logic          q_push, q_flush;
    logic [7:0]    q_data;
    logic [CW-1:0] fifo_count;

    kms_lock_filter u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (lock_take),
        .sel    (key_lock),
        .key_up (key_up),
        .pass   (lock_pass)
    );

    kms_mouse_enc #(.MW(MW)) u_menc (
        .dx  (mouse_dx),
        .dy  (mouse_dy),
        .btn (mouse_btn),
        .hdr (m_hdr),
        .mx  (m_dx),
        .my  (m_dy)
    );

    kms_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_valid    (key_valid),
        .key_code     (key_code),
        .key_up       (key_up),
        .lock_pass    (lock_pass),
        .mouse_valid  (mouse_valid),
        .m_hdr        (m_hdr),
        .m_dx         (m_dx),
        .m_dy         (m_dy),
        .host_valid   (host_valid),
        .host_byte    (host_byte),
        .tx_enable    (tx_enable),
        .chan_disable (chan_disable),
        .ev_ready     (ev_ready),
        .lock_take    (lock_take),
        .push         (q_push),
        .push_data    (q_data),
        .flush        (q_flush)
    );

    kms_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_data),
        .pop       (out_pop),
        .flush     (q_flush),
        .head      (out_byte),
        .not_empty (out_avail),
        .count     (fifo_count)
    );
endmodule

// File: rtl/kbd_mouse_src_chk.sv
module kbd_mouse_src_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_avail,
    input logic [7:0]    out_byte,
    input logic          out_pop,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_push,
    input logic          fifo_flush,
    input logic          key_valid,
    input logic [1:0]    key_lock,
    input logic          ev_ready
);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_count == CW'(DEPTH) && !out_pop && !fifo_flush)
        |=> (fifo_count == CW'(DEPTH)));

    // R3
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_avail |-> (out_byte == 8'h00));

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pop && !out_avail && !fifo_push && !fifo_flush) |=> !out_avail);

    // R4
    avail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pop && fifo_count > CW'(1) && !fifo_flush) |=> out_avail);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> (fifo_count == '0));

    // R13
    key_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ready && key_valid && key_lock == 2'd0) |=> !ev_ready);
endmodule

bind kbd_mouse_src kbd_mouse_src_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_avail  (out_avail),
    .out_byte   (out_byte),
    .out_pop    (out_pop),
    .fifo_count (fifo_count),
    .fifo_push  (q_push),
    .fifo_flush (q_flush),
    .key_valid  (key_valid),
    .key_lock   (key_lock),
    .ev_ready   (ev_ready)
);

// File: tb/tb_kbd_mouse_src.sv
module tb_kbd_mouse_src;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int MW = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic key_valid = 0, key_up = 0;
    logic [7:0] key_code = 0;
    logic [1:0] key_lock = 0;
    logic mouse_valid = 0;
    logic [MW-1:0] mouse_dx = 0, mouse_dy = 0;
    logic [2:0] mouse_btn = 0;
    logic host_valid = 0;
    logic [7:0] host_byte = 0;
    logic tx_enable = 1, chan_disable = 0;
    logic ev_ready, out_avail, out_pop = 0;
    logic [7:0] out_byte;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_mouse_src #(.DEPTH(DEPTH), .MW(MW)) dut (.*);

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got hang exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    // offers the set valids and releases each once taken
    task automatic offer();
        while (key_valid || mouse_valid || host_valid) begin
            while (!ev_ready) @(negedge clk);
            @(negedge clk);
            if (key_valid) key_valid = 0;
            else if (mouse_valid) mouse_valid = 0;
            else host_valid = 0;
        end
        while (!ev_ready) @(negedge clk);
    endtask

    task automatic key(input logic [7:0] c, input logic up, input logic [1:0] lk);
        @(negedge clk);
        key_code = c; key_up = up; key_lock = lk; key_valid = 1;
        offer();
    endtask

    task automatic host(input logic [7:0] b);
        @(negedge clk);
        host_byte = b; host_valid = 1;
        offer();
    endtask

    task automatic mouse(input int dx, input int dy, input logic [2:0] b);
        @(negedge clk);
        mouse_dx = MW'(dx); mouse_dy = MW'(dy); mouse_btn = b; mouse_valid = 1;
        offer();
    endtask

    function automatic logic [7:0] sat(input int v);
        int c;
        c = (v > 127) ? 127 : ((v < -127) ? -127 : v);
        return 8'(c);
    endfunction

    function automatic void exp_mouse(input int dx, input int dy, input logic [2:0] b);
        exp_q.push_back(8'h87 & ~{5'b0, b});
        exp_q.push_back(sat(dx));
        exp_q.push_back(sat(-dy));
        exp_q.push_back(8'h00);
        exp_q.push_back(8'h00);
    endfunction

    // pops and compares against exp_q, then expects empty
    task automatic drain(input string tag);
        while (exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check({tag, " avail"}, {7'b0, out_avail}, 8'h01);
            check(tag, out_byte, e);
            out_pop = 1;
            @(negedge clk);
            out_pop = 0;
        end
        check({tag, " empty"}, {7'b0, out_avail}, 8'h00);
    endtask

    int dl[13] = '{-512, -300, -128, -127, -126, -1, 0, 1, 126, 127, 128, 300, 511};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 avail", {7'b0, out_avail}, 8'h00);
        check("R1 byte", out_byte, 8'h00);
        check("R1 ready", {7'b0, ev_ready}, 8'h01);

        // R5 press and release over all 7-bit codes
        for (int c = 0; c < 128; c++) begin
            key(8'(c), 0, 2'd0);
            key(8'(c), 1, 2'd0);
            exp_q.push_back(8'(c));
            exp_q.push_back(8'(c) | 8'h80);
            drain("R5 key");
        end

        // R7 R8 mouse sweep
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < 13; i++) begin
                mouse(dl[i], dl[(i + b) % 13], 3'(b));
                exp_mouse(dl[i], dl[(i + b) % 13], 3'(b));
                drain("R8 mouse");
            end
        end

        // R6 lock filtering, caps and num independent
        key(8'h77, 0, 2'd1);  // caps st 1 send
        key(8'h62, 0, 2'd2);  // num st 1 send
        key(8'h77, 1, 2'd1);  // caps st 3 drop
        key(8'h77, 0, 2'd1);  // caps st 2 drop
        key(8'h62, 1, 2'd2);  // num st 3 drop
        key(8'h77, 1, 2'd1);  // caps st 0 send
        key(8'h62, 0, 2'd2);  // num st 2 drop
        key(8'h62, 1, 2'd2);  // num st 0 send
        key(8'h77, 0, 2'd3);  // none
        exp_q = '{8'h77, 8'h62, 8'hF7, 8'hE2, 8'h77};
        drain("R6 lock");

        // R2 overflow keeps first DEPTH bytes
        for (int i = 0; i < DEPTH + 4; i++) begin
            key(8'h10 + 8'(i), 0, 2'd0);
            if (i < DEPTH) exp_q.push_back(8'h10 + 8'(i));
        end
        drain("R2 full");
        // R3 pop when empty
        check("R3 empty byte", out_byte, 8'h00);
        out_pop = 1; @(negedge clk); out_pop = 0;
        check("R3 empty pop", {7'b0, out_avail}, 8'h00);
        key(8'h5A, 0, 2'd0);
        exp_q.push_back(8'h5A);
        drain("R3 after pop");

        // R4 avail held between pops
        for (int i = 0; i < 3; i++) key(8'h20 + 8'(i), 0, 2'd0);
        out_pop = 1; @(negedge clk); out_pop = 0;
        check("R4 avail", {7'b0, out_avail}, 8'h01);
        exp_q = '{8'h21, 8'h22};
        drain("R4 rest");

        // R12 host ignored when disabled paths
        key(8'h33, 0, 2'd0);
        tx_enable = 0;
        host(8'h01);
        host(8'h0E);
        tx_enable = 1; chan_disable = 1;
        host(8'h07);
        chan_disable = 0;
        host(8'h55);
        exp_q.push_back(8'h33);
        drain("R12 ignored");

        // R9 identify flushes then replies (arm not set by ignored 0x0E)
        key(8'h44, 0, 2'd0);
        host(8'h01);
        exp_q = '{8'hFF, 8'h04, 8'h7F};
        drain("R9 ident");

        // R10 arm swallows next byte
        key(8'h45, 0, 2'd0);
        host(8'h0E);
        host(8'h01);
        exp_q.push_back(8'h45);
        drain("R10 swallow");
        host(8'h01);
        exp_q = '{8'hFF, 8'h04, 8'h7F};
        drain("R10 after");

        // R11 layout queries
        key(8'h55, 0, 2'd0);
        host(8'h07);
        exp_q = '{8'hFE, 8'h21};
        drain("R11 q07");
        host(8'h0F);
        exp_q = '{8'hFE, 8'h21};
        drain("R11 q0F");

        // R13 key before mouse
        @(negedge clk);
        key_code = 8'h19; key_up = 0; key_lock = 0; key_valid = 1;
        mouse_dx = MW'(5); mouse_dy = MW'(-9); mouse_btn = 3'b101; mouse_valid = 1;
        offer();
        exp_q.push_back(8'h19);
        exp_mouse(5, -9, 3'b101);
        drain("R13 key-mouse");
        // R13 key before host flush
        @(negedge clk);
        key_code = 8'h1A; key_valid = 1;
        host_byte = 8'h01; host_valid = 1;
        offer();
        exp_q = '{8'hFF, 8'h04, 8'h7F};
        drain("R13 key-host");
        // R13 busy while pushing
        @(negedge clk);
        key_code = 8'h1B; key_valid = 1;
        @(negedge clk);
        key_valid = 0;
        check("R13 busy", {7'b0, ev_ready}, 8'h00);
        offer();
        exp_q.push_back(8'h1B);
        drain("R13 single");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule